// File: doc/BRIEF.md
# Page write-protection arbiter

This block decides whether a row write coming from a serial-interface front end may reach a small nonvolatile array, and what data the array should program. The array holds four pages of 32 bytes, and each page is divided into four 8-byte rows, which are the unit of programming. Each write request carries a page and row address, eight new bytes, the row's current contents as read from the array, and a flag that is true when the external 160-bit MAC comparison for this write has succeeded.

Every page has its own protection mode. An open page takes new data as it is. A page in one-time-programmable emulation only lets bits go from 1 to 0, so the programmed row is the bitwise AND of old and new data. A locked page rejects every write. Modes can only move toward stricter settings. A request is accepted only from idle. An accepted request raises a one-cycle commit strobe with the merged row, and a busy flag stays set until the array acknowledges completion. Every request, accepted or not, returns a one-cycle response with an error code.

Top module: `pwp_arbiter`

## Requirements
- R1: After a synchronous reset, commit, busy, response valid and the warning flag are 0, the error code is 0, and every page is in open mode.
- R2: An authorized request to an open page while idle produces, in the cycle after the request, a commit pulse exactly one cycle long, the new data unchanged as commit data, the request's page and row as the commit address, and a response with code 0 (accepted).
- R3: For an accepted request to a page in mode 1 (one-time-programmable emulation), the commit data is the old row contents ANDed with the new data.
- R4: The warning flag is set by an accepted request to a mode 1 page whose new data has a 1 where the old row has a 0. The flag is not set by such data on an open page or by clean mode 1 data, and once set it stays set until reset.
- R5: A request to a page in mode 2 (locked) gets response code 1 and no commit, whatever its authorization flag.
- R6: An unauthorized request to a page that is not locked gets response code 2 and no commit.
- R7: Busy rises together with the commit strobe and falls in the cycle after done is sampled high. A request made while busy gets response code 3 and no commit. Done sampled while idle has no effect.
- R8: A mode request for a page takes effect only when the requested mode code is greater than the page's current code (0 open, 1 emulation, 2 locked). Lower or equal codes and code 3 are ignored.
- R9: Every request produces exactly one response-valid pulse in the following cycle. The error code is kept until the next response, and the order of checks is busy, then locked, then unauthorized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Row write request, one cycle |
| req_page_i | input | PAGE_W | Page addressed by the request |
| req_row_i | input | ROW_W | Row inside the page |
| req_data_i | input | ROW_BITS | New row data |
| old_data_i | input | ROW_BITS | Current row contents read from the array |
| auth_ok_i | input | 1 | MAC comparison for this write succeeded |
| mode_set_i | input | 1 | Mode change request, one cycle |
| mode_page_i | input | PAGE_W | Page whose mode is to change |
| mode_val_i | input | 2 | Requested mode code |
| done_i | input | 1 | Array finished programming |
| commit_o | output | 1 | Program strobe, one cycle |
| commit_page_o | output | PAGE_W | Page to program |
| commit_row_o | output | ROW_W | Row to program |
| commit_data_o | output | ROW_BITS | Merged row to program |
| busy_o | output | 1 | Commit outstanding |
| resp_valid_o | output | 1 | Response to a request, one cycle |
| err_code_o | output | 2 | 0 accepted, 1 locked, 2 unauthorized, 3 busy |
| warn_o | output | 1 | Sticky: a cleared bit was asked to be set |

## Verification
Writes to an open page use new data that sets bits the old row has clear. The result has to equal the new data, with no warning, which separates open mode from emulation. On an emulation page, the old and new patterns are first chosen so that new data only clears bits, giving an AND result with the warning low. They are then chosen so that new data tries to set bits, giving a different AND result and the warning raised. Locked pages are written with authorization both present and absent to show that locking takes priority. Requests during busy, done while idle, and mode requests to lower, equal and invalid codes show that rejected stimulus leaves the commit path and the page modes untouched.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
  typedef enum logic [1:0] {
    MODE_OPEN   = 2'd0,
    MODE_EPROM  = 2'd1,
    MODE_LOCKED = 2'd2
  } pmode_t;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_LOCKED = 2'd1,
    ERR_NOAUTH = 2'd2,
    ERR_BUSY   = 2'd3
  } perr_t;
endpackage

// File: rtl/pwp_mode_table.sv
module pwp_mode_table #(
  parameter int PAGES  = 4,
  parameter int PAGE_W = $clog2(PAGES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 set_i,
  input  logic [PAGE_W-1:0]    page_i,
  input  logic [1:0]           val_i,
  output logic [2*PAGES-1:0]   modes_o
);
  import pwp_pkg::*;

  for (genvar g = 0; g < PAGES; g++) begin : g_page
    logic [1:0] mode_q;
    logic       hit;

    assign hit = set_i && (page_i == PAGE_W'(g)) && (val_i != 2'd3) && (val_i > mode_q);

    always_ff @(posedge clk) begin
      if (rst) mode_q <= MODE_OPEN;
      else if (hit) mode_q <= val_i;
    end

    assign modes_o[2*g +: 2] = mode_q;

    // R8: a page's mode never moves back and never takes the invalid code
    a_r8_mode_monotone: assert property (@(posedge clk) disable iff (rst)
      (mode_q >= $past(mode_q)) && (mode_q != 2'd3));
  end
endmodule

// File: rtl/pwp_row_merge.sv
module pwp_row_merge #(
  parameter int ROW_BITS = 64
) (
  input  logic [1:0]          mode_i,
  input  logic [ROW_BITS-1:0] new_i,
  input  logic [ROW_BITS-1:0] old_i,
  output logic [ROW_BITS-1:0] merged_o,
  output logic                set_attempt_o
);
  import pwp_pkg::*;

  logic emul;
  assign emul = (mode_i == MODE_EPROM);

  always_comb begin
    merged_o      = emul ? (old_i & new_i) : new_i;
    set_attempt_o = emul && (|(new_i & ~old_i));
  end
endmodule

// File: rtl/pwp_arbiter.sv
module pwp_arbiter #(
  parameter int PAGES         = 4,
  parameter int ROWS_PER_PAGE = 4,
  parameter int ROW_BYTES     = 8,
  localparam int PAGE_W       = $clog2(PAGES),
  localparam int ROW_W        = $clog2(ROWS_PER_PAGE),
  localparam int ROW_BITS     = 8 * ROW_BYTES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid_i,
  input  logic [PAGE_W-1:0]   req_page_i,
  input  logic [ROW_W-1:0]    req_row_i,
  input  logic [ROW_BITS-1:0] req_data_i,
  input  logic [ROW_BITS-1:0] old_data_i,
  input  logic                auth_ok_i,
  input  logic                mode_set_i,
  input  logic [PAGE_W-1:0]   mode_page_i,
  input  logic [1:0]          mode_val_i,
  input  logic                done_i,
  output logic                commit_o,
  output logic [PAGE_W-1:0]   commit_page_o,
  output logic [ROW_W-1:0]    commit_row_o,
  output logic [ROW_BITS-1:0] commit_data_o,
  output logic                busy_o,
  output logic                resp_valid_o,
  output logic [1:0]          err_code_o,
  output logic                warn_o
);
  import pwp_pkg::*;

  logic [2*PAGES-1:0]   modes;
  logic [1:0]           cur_mode;
  logic [ROW_BITS-1:0]  merged;
  logic                 set_attempt;

  pwp_mode_table #(.PAGES(PAGES), .PAGE_W(PAGE_W)) i_modes (
    .clk(clk), .rst(rst), .set_i(mode_set_i), .page_i(mode_page_i),
    .val_i(mode_val_i), .modes_o(modes)
  );

  assign cur_mode = modes[2*req_page_i +: 2];

  pwp_row_merge #(.ROW_BITS(ROW_BITS)) i_merge (
    .mode_i(cur_mode), .new_i(req_data_i), .old_i(old_data_i),
    .merged_o(merged), .set_attempt_o(set_attempt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_o      <= 1'b0;
      commit_page_o <= '0;
      commit_row_o  <= '0;
      commit_data_o <= '0;
      busy_o        <= 1'b0;
      resp_valid_o  <= 1'b0;
      err_code_o    <= ERR_NONE;
      warn_o        <= 1'b0;
    end else begin
      commit_o     <= 1'b0;
      resp_valid_o <= 1'b0;
      if (busy_o && done_i) busy_o <= 1'b0;
      if (req_valid_i) begin
        resp_valid_o <= 1'b1;
        if (busy_o)                      err_code_o <= ERR_BUSY;
        else if (cur_mode == MODE_LOCKED) err_code_o <= ERR_LOCKED;
        else if (!auth_ok_i)             err_code_o <= ERR_NOAUTH;
        else begin
          err_code_o    <= ERR_NONE;
          commit_o      <= 1'b1;
          busy_o        <= 1'b1;
          commit_page_o <= req_page_i;
          commit_row_o  <= req_row_i;
          commit_data_o <= merged;
          if (set_attempt) warn_o <= 1'b1;
        end
      end
    end
  end

  // R2: a commit only accompanies an accepted response
  a_r2_commit_accepted: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> (resp_valid_o && err_code_o == ERR_NONE));

  // R5, R6: a rejected response never carries a commit
  a_r5_reject_no_commit: assert property (@(posedge clk) disable iff (rst)
    (resp_valid_o && err_code_o != ERR_NONE) |-> !commit_o);

  // R7: commits start only from idle and come with busy
  a_r7_commit_from_idle: assert property (@(posedge clk) disable iff (rst)
    commit_o |-> (busy_o && !$past(busy_o)));

  // R7: busy only drops after done was seen
  a_r7_busy_needs_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(done_i));

  // R4: the warning is sticky
  a_r4_warn_sticky: assert property (@(posedge clk) disable iff (rst)
    !$fell(warn_o));

  // R3: an emulation commit never sets a bit that the old row had clear
  a_r3_clear_only: assert property (@(posedge clk) disable iff (rst)
    (commit_o && $past(cur_mode) == MODE_EPROM) |->
      ((commit_data_o & ~$past(old_data_i)) == '0));

  // R9: each request is answered in the next cycle
  a_r9_response: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> resp_valid_o);
endmodule

// File: tb/test_pwp_arbiter.sv
module test_pwp_arbiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid_i = 1'b0;
  logic [1:0]  req_page_i = '0;
  logic [1:0]  req_row_i = '0;
  logic [63:0] req_data_i = '0;
  logic [63:0] old_data_i = '0;
  logic        auth_ok_i = 1'b0;
  logic        mode_set_i = 1'b0;
  logic [1:0]  mode_page_i = '0;
  logic [1:0]  mode_val_i = '0;
  logic        done_i = 1'b0;
  logic        commit_o;
  logic [1:0]  commit_page_o;
  logic [1:0]  commit_row_o;
  logic [63:0] commit_data_o;
  logic        busy_o;
  logic        resp_valid_o;
  logic [1:0]  err_code_o;
  logic        warn_o;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  pwp_arbiter i_pwp_arbiter (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_page_i(req_page_i),
    .req_row_i(req_row_i), .req_data_i(req_data_i), .old_data_i(old_data_i),
    .auth_ok_i(auth_ok_i), .mode_set_i(mode_set_i), .mode_page_i(mode_page_i),
    .mode_val_i(mode_val_i), .done_i(done_i), .commit_o(commit_o),
    .commit_page_o(commit_page_o), .commit_row_o(commit_row_o),
    .commit_data_o(commit_data_o), .busy_o(busy_o), .resp_valid_o(resp_valid_o),
    .err_code_o(err_code_o), .warn_o(warn_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write(input logic [1:0] pg, input logic [1:0] rw,
                       input logic [63:0] nd, input logic [63:0] od, input logic au);
    @(negedge clk);
    req_valid_i = 1'b1; req_page_i = pg; req_row_i = rw;
    req_data_i = nd; old_data_i = od; auth_ok_i = au;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] pg, input logic [1:0] v);
    @(negedge clk);
    mode_set_i = 1'b1; mode_page_i = pg; mode_val_i = v;
    @(posedge clk);
    @(negedge clk);
    mode_set_i = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    done_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    done_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 commit", 64'(commit_o), 64'd0);
    chk("R1 busy", 64'(busy_o), 64'd0);
    chk("R1 resp_valid", 64'(resp_valid_o), 64'd0);
    chk("R1 warn", 64'(warn_o), 64'd0);
    chk("R1 err", 64'(err_code_o), 64'd0);
  endtask

  task automatic t_open_write();
    write(2'd0, 2'd2, 64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 1'b1);
    chk("R2 commit", 64'(commit_o), 64'd1);
    chk("R2 data", commit_data_o, 64'h0123_4567_89AB_CDEF);
    chk("R2 page", 64'(commit_page_o), 64'd0);
    chk("R2 row", 64'(commit_row_o), 64'd2);
    chk("R9 resp", 64'(resp_valid_o), 64'd1);
    chk("R2 err", 64'(err_code_o), 64'd0);
    chk("R7 busy", 64'(busy_o), 64'd1);
    chk("R4 no warn open", 64'(warn_o), 64'd0);
    @(negedge clk);
    chk("R2 one cycle", 64'(commit_o), 64'd0);
    chk("R9 one resp", 64'(resp_valid_o), 64'd0);
    chk("R9 err held", 64'(err_code_o), 64'd0);
    chk("R7 busy held", 64'(busy_o), 64'd1);
    ack();
    chk("R7 busy drop", 64'(busy_o), 64'd0);
  endtask

  task automatic t_busy();
    write(2'd1, 2'd3, 64'h1111, 64'h0, 1'b1);
    chk("R7 accepted", 64'(commit_o), 64'd1);
    write(2'd1, 2'd0, 64'h2222, 64'h0, 1'b1);
    chk("R7 busy reject commit", 64'(commit_o), 64'd0);
    chk("R7 busy err", 64'(err_code_o), 64'd3);
    chk("R7 busy data kept", commit_data_o, 64'h1111);
    ack();
    ack();
    chk("R7 idle done", 64'(busy_o), 64'd0);
    write(2'd1, 2'd1, 64'h3333, 64'h0, 1'b1);
    chk("R7 after idle done", 64'(commit_o), 64'd1);
    ack();
  endtask

  task automatic t_eprom();
    set_mode(2'd2, 2'd1);
    write(2'd2, 2'd1, 64'hF000_F000_0F00_0F00, 64'hFF00_FF00_FF00_FF00, 1'b1);
    chk("R3 clean data", commit_data_o, 64'hF000_F000_0F00_0F00);
    chk("R4 clean no warn", 64'(warn_o), 64'd0);
    ack();
    write(2'd2, 2'd0, 64'h0F0F_0F0F_0F0F_0F0F, 64'h00FF_00FF_00FF_00FF, 1'b1);
    chk("R3 and data", commit_data_o, 64'h000F_000F_000F_000F);
    chk("R4 warn set", 64'(warn_o), 64'd1);
    ack();
    write(2'd0, 2'd0, 64'h5, 64'h0, 1'b1);
    chk("R4 sticky", 64'(warn_o), 64'd1);
    ack();
  endtask

  task automatic t_locked();
    set_mode(2'd3, 2'd2);
    write(2'd3, 2'd0, 64'hAA, 64'h0, 1'b1);
    chk("R5 no commit", 64'(commit_o), 64'd0);
    chk("R5 err", 64'(err_code_o), 64'd1);
    chk("R5 not busy", 64'(busy_o), 64'd0);
    write(2'd3, 2'd0, 64'hAA, 64'h0, 1'b0);
    chk("R9 locked before noauth", 64'(err_code_o), 64'd1);
  endtask

  task automatic t_noauth();
    write(2'd0, 2'd1, 64'hBB, 64'h0, 1'b0);
    chk("R6 no commit", 64'(commit_o), 64'd0);
    chk("R6 err", 64'(err_code_o), 64'd2);
    chk("R6 resp", 64'(resp_valid_o), 64'd1);
  endtask

  task automatic t_oneway();
    set_mode(2'd3, 2'd0);
    write(2'd3, 2'd0, 64'hCC, 64'h0, 1'b1);
    chk("R8 locked stays", 64'(err_code_o), 64'd1);
    set_mode(2'd2, 2'd0);
    set_mode(2'd2, 2'd1);
    write(2'd2, 2'd2, 64'hF0, 64'h3C, 1'b1);
    chk("R8 emul stays", commit_data_o, 64'h30);
    ack();
    set_mode(2'd0, 2'd3);
    write(2'd0, 2'd3, 64'hF0, 64'h3C, 1'b1);
    chk("R8 code3 ignored", commit_data_o, 64'hF0);
    ack();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_open_write();
    t_busy();
    t_eprom();
    t_locked();
    t_noauth();
    t_oneway();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #400000;
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule